// File: doc/BRIEF.md
# Attention-Line Arbitrated Serial Frame Sender

This block puts one frame onto a shared half-duplex serial bus. Many nodes share the data wire. A separate open-drain attention wire decides which node may talk. The block keeps a single-cycle request, made of a frame identifier and a payload length, only if the synchronised attention wire reads high. It then pulls that wire low and waits a guard time of two bit periods. After that it reads the frame bytes one at a time from a byte source through a read port with one cycle of latency, and shifts them out as asynchronous serial characters. When the last stop bit has fully left the line, it lets go of the attention wire.

The block keeps two wrapping 16-bit event counters: refused requests and frames sent. It shows the identifier of the frame in flight, and the all-ones value when nothing is in flight. After it releases the wire, it ignores requests for a programmable number of cycles, so the wire stays high for a minimum time (10 µs at the intended clock) before any new claim. The bit rate comes from a clock divider. With the default values and a 100 MHz clock it is about 19200 baud.

Top module: `attn_frame_tx`

## Requirements
- R1: In idle, `req_valid` is looked at for one cycle only. The attention input first passes through a two-stage synchroniser. If the synchronised value is high, the request is accepted. In the next cycle `req_ok` pulses, `attn_oe` and `attn_lo` are both 1, and `cur_id` shows `req_id`.
- R2: If the synchronised attention value is low, the request is refused. `req_nak` pulses for one cycle and `nak_count` goes up by one. The attention wire is not driven. A wire that was released only one cycle before the request is still seen as low.
- R3: The falling edge of the first start bit comes exactly 2×`CLKS_PER_BIT` cycles after the cycle in which `attn_oe` became 1.
- R4: The frame is `req_len`+3 bytes long. The bytes are read from `rd_addr` = 0, 1, 2, … in order. `rd_data` is the byte at the address presented in the cycle before.
- R5: Each byte is sent as one start bit (0), then 8 data bits with the least significant bit first, then two stop bits (1). Every bit lasts `CLKS_PER_BIT` cycles. Bytes follow each other with no idle gap.
- R6: `done` pulses and `attn_oe` returns to 0 at the end of the last stop bit, that is 11×`CLKS_PER_BIT`×(`req_len`+3) cycles after the first start bit begins.
- R7: Each completed frame adds one to `sent_count`.
- R8: After the wire is released, `busy` stays 1 and requests get neither `req_ok` nor `req_nak` for `HOLD_CYCLES` cycles. Then the block is idle again.
- R9: `cur_id` is all ones (0xFF for the default width) whenever no frame is in flight.
- R10: Requests that arrive while a frame is in flight are ignored. No pulse is given and `cur_id` does not change.
- R11: `txd` is 1 whenever the block is not driving the attention wire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Single-cycle send request |
| req_id | input | ID_W | Identifier of the frame to send |
| req_len | input | LEN_W | Payload length field |
| req_ok | output | 1 | Request accepted (pulse) |
| req_nak | output | 1 | Request refused, attention wire held low (pulse) |
| busy | output | 1 | Block is not idle |
| done | output | 1 | Frame fully sent (pulse) |
| rd_addr | output | LEN_W+1 | Byte index into the frame source |
| rd_data | input | 8 | Source byte for the previous cycle's address |
| txd | output | 1 | Serial data, idles high |
| attn_in | input | 1 | Attention wire as read from the pad |
| attn_oe | output | 1 | Attention pad output enable |
| attn_lo | output | 1 | Attention pad drive-low value |
| cur_id | output | ID_W | Identifier in flight, all ones when none |
| nak_count | output | 16 | Refused-request counter |
| sent_count | output | 16 | Sent-frame counter |

## Verification
Several rules hold on every cycle and are guarded by properties:
- a claim happens only after a high synchronised sample,
- a refusal always advances its counter,
- `txd` stays high while the wire is released,
- completion releases the wire and counts the frame,
- `cur_id` holds the all-ones value outside a frame,
- the start and stop bits have the right levels.

Some behaviour can only be shown by the bench's scenarios, which measure cycle counts:
- the exact two-bit guard time,
- the byte order and count for zero and non-zero payload lengths,
- the total frame duration,
- the length of the hold window,
- requests being ignored during a frame,
- the synchroniser delay on a wire that was just released.

// File: rtl/attn_tx_pkg.sv
package attn_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GUARD = 2'd1,
    ST_SEND  = 2'd2,
    ST_HOLD  = 2'd3
  } tx_state_e;

  localparam int SER_DATA_BITS = 8;
  localparam int SER_STOP_BITS = 2;
  localparam int FRAME_OVERHEAD = 3;
endpackage

// File: rtl/attn_sync.sv
module attn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '1;
        else        ff_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '1;
        else        ff_q <= {ff_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/baud_tick.sv
module baud_tick #(
  parameter int DIV = 5208
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV < 2) ? 1 : $clog2(DIV);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (cnt_q == CW'(DIV - 1));
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/byte_ser.sv
module byte_ser #(
  parameter int DATA_W    = 8,
  parameter int STOP_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              tick,
  output logic              txd,
  output logic              active,
  output logic              fin
);
  localparam int FW  = DATA_W + 1 + STOP_BITS;
  localparam int BCW = $clog2(FW);

  logic [FW-1:0]  sreg_q, sreg_d;
  logic [BCW-1:0] bit_q, bit_d;
  logic           act_q, act_d;
  logic           last_bit;

  always_comb begin
    last_bit = (bit_q == BCW'(FW - 1));
    fin      = act_q && tick && last_bit;
    sreg_d   = sreg_q;
    bit_d    = bit_q;
    act_d    = act_q;
    if (load) begin
      sreg_d = {{STOP_BITS{1'b1}}, din, 1'b0};
      bit_d  = '0;
      act_d  = 1'b1;
    end else if (act_q && tick) begin
      if (last_bit) begin
        act_d = 1'b0;
      end else begin
        sreg_d = {1'b1, sreg_q[FW-1:1]};
        bit_d  = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '1;
      bit_q  <= '0;
      act_q  <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      bit_q  <= bit_d;
      act_q  <= act_d;
    end
  end

  assign txd    = act_q ? sreg_q[0] : 1'b1;
  assign active = act_q;

  // R5: a freshly started character opens with a low start bit
  assert_start_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> !txd);
  // R5: the trailing bit slots of a character are stop bits
  assert_stop_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && bit_q > BCW'(DATA_W)) |-> txd);
endmodule

// File: rtl/evt_count.sv
module evt_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = inc ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign q = cnt_q;
endmodule

// File: rtl/attn_frame_tx.sv
module attn_frame_tx
  import attn_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 5208,
  parameter int HOLD_CYCLES  = 1000,
  parameter int GUARD_BITS   = 2,
  parameter int LEN_W        = 8,
  parameter int ID_W         = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int STAT_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ok,
  output logic              req_nak,
  output logic              busy,
  output logic              done,
  output logic [LEN_W:0]    rd_addr,
  input  logic [7:0]        rd_data,
  output logic              txd,
  input  logic              attn_in,
  output logic              attn_oe,
  output logic              attn_lo,
  output logic [ID_W-1:0]   cur_id,
  output logic [STAT_W-1:0] nak_count,
  output logic [STAT_W-1:0] sent_count
);
  localparam int CNT_W = LEN_W + 1;
  localparam int HCW   = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
  localparam int GCW   = (GUARD_BITS < 2) ? 1 : $clog2(GUARD_BITS);

  tx_state_e        state_q, state_d;
  logic             claim_q, claim_d;
  logic [ID_W-1:0]  id_q, id_d;
  logic [CNT_W-1:0] total_q, total_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [GCW-1:0]   guard_q, guard_d;
  logic [HCW-1:0]   hold_q, hold_d;
  logic             ok_q, nak_q, done_q;

  logic attn_hi, tick, baud_en, baud_clr;
  logic ser_load, ser_fin, ser_active;
  logic accept, refuse, finish;

  attn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(attn_in), .q(attn_hi)
  );

  baud_tick #(.DIV(CLKS_PER_BIT)) u_baud (
    .clk(clk), .rst_n(rst_n), .clr(baud_clr), .en(baud_en), .tick(tick)
  );

  byte_ser #(.DATA_W(SER_DATA_BITS), .STOP_BITS(SER_STOP_BITS)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(ser_load), .din(rd_data), .tick(tick),
    .txd(txd), .active(ser_active), .fin(ser_fin)
  );

  evt_count #(.W(STAT_W)) u_nak_cnt (
    .clk(clk), .rst_n(rst_n), .inc(refuse), .q(nak_count)
  );

  evt_count #(.W(STAT_W)) u_sent_cnt (
    .clk(clk), .rst_n(rst_n), .inc(finish), .q(sent_count)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    claim_d  = claim_q;
    id_d     = id_q;
    total_d  = total_q;
    idx_d    = idx_q;
    guard_d  = guard_q;
    hold_d   = hold_q;
    accept   = 1'b0;
    refuse   = 1'b0;
    finish   = 1'b0;
    ser_load = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (attn_hi) begin
            accept  = 1'b1;
            claim_d = 1'b1;
            id_d    = req_id;
            total_d = CNT_W'(req_len) + CNT_W'(FRAME_OVERHEAD);
            idx_d   = '0;
            guard_d = '0;
            state_d = ST_GUARD;
          end else begin
            refuse = 1'b1;
          end
        end
      end
      ST_GUARD: begin
        if (tick) begin
          if (guard_q == GCW'(GUARD_BITS - 1)) begin
            ser_load = 1'b1;
            idx_d    = idx_q + 1'b1;
            state_d  = ST_SEND;
          end else begin
            guard_d = guard_q + 1'b1;
          end
        end
      end
      ST_SEND: begin
        if (ser_fin) begin
          if (idx_q == total_q) begin
            finish  = 1'b1;
            claim_d = 1'b0;
            id_d    = '1;
            hold_d  = '0;
            state_d = ST_HOLD;
          end else begin
            ser_load = 1'b1;
            idx_d    = idx_q + 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (hold_q == HCW'(HOLD_CYCLES - 1)) state_d = ST_IDLE;
        else                                 hold_d  = hold_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign baud_en  = (state_q == ST_GUARD) || (state_q == ST_SEND);
  assign baud_clr = accept || ser_load;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      claim_q <= 1'b0;
      id_q    <= '1;
      total_q <= '0;
      idx_q   <= '0;
      guard_q <= '0;
      hold_q  <= '0;
      ok_q    <= 1'b0;
      nak_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      claim_q <= claim_d;
      id_q    <= id_d;
      total_q <= total_d;
      idx_q   <= idx_d;
      guard_q <= guard_d;
      hold_q  <= hold_d;
      ok_q    <= accept;
      nak_q   <= refuse;
      done_q  <= finish;
    end
  end

  assign req_ok  = ok_q;
  assign req_nak = nak_q;
  assign done    = done_q;
  assign busy    = (state_q != ST_IDLE);
  assign rd_addr = idx_q;
  assign attn_oe = claim_q;
  assign attn_lo = claim_q;
  assign cur_id  = id_q;

  // R1: the wire is only claimed after a high synchronised sample
  assert_claim_when_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(attn_oe) |-> $past(attn_hi));
  // R2: every refusal advances the refusal counter by one
  assert_nak_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_nak |-> (nak_count == $past(nak_count) + 1'b1));
  // R6: completion coincides with releasing the wire
  assert_done_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!attn_oe && $past(attn_oe)));
  // R7: every completion advances the sent counter by one
  assert_sent_counts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sent_count == $past(sent_count) + 1'b1));
  // R9: all-ones identifier whenever no frame is in flight
  assert_idle_marker_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || !attn_oe) |-> (cur_id == {ID_W{1'b1}}));
  // R11: the data wire is quiet while the attention wire is released
  assert_quiet_line_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !attn_oe |-> txd);
  // R5: no character is in progress without the wire held
  assert_ser_under_claim_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_active |-> attn_oe);
endmodule

// File: tb/attn_frame_tx_test.sv
`timescale 1ns/1ps
module attn_frame_tx_test;
  localparam int N = 8;
  localparam int H = 20;

  logic        clk, rst_n;
  logic        req_valid;
  logic [7:0]  req_id, req_len;
  logic        req_ok, req_nak, busy, done;
  logic [8:0]  rd_addr;
  logic [7:0]  rd_data;
  logic        txd, attn_in, attn_oe, attn_lo;
  logic [7:0]  cur_id;
  logic [15:0] nak_count, sent_count;
  logic        ext_low;
  logic [7:0]  seed;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  byte unsigned exp_q[$];

  attn_frame_tx #(.CLKS_PER_BIT(N), .HOLD_CYCLES(H)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_len(req_len), .req_ok(req_ok), .req_nak(req_nak), .busy(busy),
    .done(done), .rd_addr(rd_addr), .rd_data(rd_data), .txd(txd),
    .attn_in(attn_in), .attn_oe(attn_oe), .attn_lo(attn_lo), .cur_id(cur_id),
    .nak_count(nak_count), .sent_count(sent_count)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // open-drain wire with pull-up; other nodes modelled by ext_low
  assign attn_in = ~((attn_oe & attn_lo) | ext_low);

  function automatic logic [7:0] byte_of(input logic [7:0] s, input int a);
    return 8'(s * 8'd7 + 8'(a * 13) + 8'(a >> 2) + 8'h5A);
  endfunction

  // byte source with one cycle of read latency
  always_ff @(posedge clk) rd_data <= byte_of(seed, int'(rd_addr));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: decodes characters on txd and compares against the scoreboard
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge txd);
      repeat (N/2) @(posedge clk);
      #1;
      check(txd == 1'b0, "R5 start bit", txd, 0);
      for (int i = 0; i < 8; i++) begin
        repeat (N) @(posedge clk);
        #1;
        b[i] = txd;
      end
      for (int s = 0; s < 2; s++) begin
        repeat (N) @(posedge clk);
        #1;
        check(txd == 1'b1, "R5 stop bit", txd, 1);
      end
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected byte", b, -1);
      end else begin
        byte unsigned e;
        e = exp_q.pop_front();
        check(b == e, "R4 byte value", b, e);
      end
    end
  end

  task automatic run_frame(input logic [7:0] id, input logic [7:0] len,
                           input logic [7:0] sd, input bit inject);
    int n, m, k, nbytes;
    bit stray, id_moved;
    logic [15:0] prev_sent;
    nbytes = int'(len) + 3;
    seed = sd;
    for (int i = 0; i < nbytes; i++) exp_q.push_back(byte_of(sd, i));
    prev_sent = sent_count;
    @(negedge clk);
    req_valid = 1'b1; req_id = id; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ok && attn_oe && attn_lo, "R1 claim", {req_ok, attn_oe, attn_lo}, 7);
    check(cur_id == id, "R9 id in flight", cur_id, id);
    n = 0;
    while (txd && n < 10000) begin @(negedge clk); n++; end
    check(n == 2 * N, "R3 guard time", n, 2 * N);
    m = 0; stray = 0; id_moved = 0;
    while (!done && m < 100000) begin
      @(negedge clk);
      m++;
      if (inject && m == 30) begin
        req_valid = 1'b1; req_id = id + 8'd1; req_len = 8'd1;
      end else begin
        req_valid = 1'b0;
      end
      if (req_ok || req_nak) stray = 1;
      if (!done && cur_id != id) id_moved = 1;
    end
    check(m == 11 * N * nbytes, "R6 frame duration", m, 11 * N * nbytes);
    check(!attn_oe, "R6 release", attn_oe, 0);
    check(sent_count == prev_sent + 16'd1, "R7 sent count", sent_count, prev_sent + 1);
    check(cur_id == 8'hFF, "R9 idle marker", cur_id, 255);
    check(exp_q.size() == 0, "R4 byte count", exp_q.size(), 0);
    if (inject) check(!stray && !id_moved, "R10 ignore during frame", {stray, id_moved}, 0);
    // hold window
    req_valid = 1'b1; req_id = id; req_len = 8'd0;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ok && !req_nak && busy && !attn_oe, "R8 ignored in hold",
          {req_ok, req_nak, busy, attn_oe}, 2);
    k = 1;
    while (busy && k < 1000) begin @(negedge clk); k++; end
    check(k == H, "R8 hold length", k, H);
  endtask

  task automatic refuse_once();
    logic [15:0] prev;
    prev = nak_count;
    @(negedge clk);
    req_valid = 1'b1; req_id = 8'h77; req_len = 8'd4;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_nak && !req_ok, "R2 refusal pulse", {req_nak, req_ok}, 2);
    check(nak_count == prev + 16'd1, "R2 refusal count", nak_count, prev + 1);
    check(!attn_oe && !busy, "R2 wire untouched", {attn_oe, busy}, 0);
    check(txd == 1'b1, "R11 quiet line", txd, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_id = '0; req_len = '0;
    ext_low = 1'b0; seed = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(txd && !attn_oe && !busy, "R11 reset state", {txd, attn_oe, busy}, 4);
    check(cur_id == 8'hFF, "R9 reset marker", cur_id, 255);
    check(nak_count == 0 && sent_count == 0, "R7 reset counters", sent_count, 0);

    run_frame(8'h11, 8'd0, 8'd3, 1'b0);
    run_frame(8'h22, 8'd5, 8'd9, 1'b1);

    ext_low = 1'b1;
    repeat (4) @(negedge clk);
    refuse_once();
    refuse_once();
    // wire released one cycle before the request is still seen low
    ext_low = 1'b0;
    refuse_once();
    repeat (4) @(negedge clk);

    run_frame(8'h33, 8'd2, 8'h55, 1'b0);
    check(sent_count == 16'd3, "R7 total sent", sent_count, 3);
    check(nak_count == 16'd3, "R2 total refused", nak_count, 3);

    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule